// File: doc/BRIEF.md
# Vector Fetch Fault Substitution Unit

This unit sits in the exception-entry path of a processor. When an exception is accepted, the unit reads the handler address for that exception from the vector table. The read uses a request/response handshake that allows one outstanding access at a time. If the read completes cleanly, the unit presents the fetched vector together with the priority level that the interrupt controller supplied. It then pulses an acknowledge so that the exception is consumed.

If the table read ends in a bus error, the returned data is not used. The unit does not raise a bus-error trap. Instead it takes these four actions:

- It sets a vector-fail status bit.
- It presents the contents of a software-writable substitute-address register as the target.
- It forces the priority level to the bus-error trap level, which is 14.
- It withholds the acknowledge, so the failed exception stays pending and can be retried.

In both the clean and the faulted case, the exception's level and vector number are handed to the trap-information register of the interrupt controller. Bus errors on any other access still take the normal trap path. A return-from-exception restores a status value whose fail bit is clear.

Top module: `vec_fault_sub`

## Requirements
- R1: A clean vector read (mem_ack with mem_err low) produces, one cycle after the response, a one-cycle vec_valid with vec_target equal to mem_rdata, vec_ipl equal to the accepted exc_level, vec_fail low and a one-cycle exc_ack in the same cycle.
- R2: An errored vector read (mem_err high) produces, one cycle after the response, a vec_valid with vec_target equal to the substitute register, vec_ipl equal to 14, vec_fail high, sr_vf set, and no exc_ack.
- R3: An errored vector read never raises berr_trap_req. A bus error on any other access (other_berr high) raises berr_trap_req exactly one cycle later.
- R4: After reset, the substitute register reads back RESET_ADDR (default 0x200). A write through sfr_we stores sfr_wdata with bit 0 forced to 0.
- R5: If the substitute register is written in the same cycle as an errored response, the pre-write value is used as vec_target. The new value is visible on sfr_rdata afterwards.
- R6: Every completed fetch, clean or errored, pulses tinfo_we together with vec_valid, carrying the accepted level on tinfo_level and the vector number on tinfo_vnum.
- R7: A ret_pulse clears sr_vf in the next cycle, restoring the clear value that was stacked. If an errored response arrives in the same cycle, sr_vf stays set.
- R8: One cycle after exc_take is accepted while idle, mem_req rises with mem_addr = VTAB_BASE + vector number × 4 (default VTAB_BASE 0x4). mem_req and mem_addr hold steady until a response arrives. mem_req drops in the cycle vec_valid is high.
- R9: exc_take is ignored while a fetch is outstanding: the accepted level and vector number are not replaced.
- R10: vec_target, vec_ipl and vec_fail hold their values between vec_valid pulses. sr_vf, once set, stays set until a ret_pulse.
- R11: After reset, mem_req, vec_valid, exc_ack, tinfo_we, berr_trap_req and sr_vf are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_take | input | 1 | An exception has been accepted; start the vector fetch |
| exc_level | input | 4 | Priority level requested by the interrupt controller |
| exc_vnum | input | 8 | Vector number of the accepted exception |
| mem_req | output | 1 | Vector table read request |
| mem_addr | output | 32 | Vector table read address |
| mem_ack | input | 1 | Read completed cleanly |
| mem_err | input | 1 | Read completed with a bus error |
| mem_rdata | input | 32 | Read data |
| vec_valid | output | 1 | One-cycle pulse: target and level are ready |
| vec_target | output | 32 | Chosen handler address |
| vec_ipl | output | 4 | Level the processor takes |
| vec_fail | output | 1 | The target was substituted |
| exc_ack | output | 1 | The exception is consumed (clean fetch only) |
| tinfo_we | output | 1 | Write strobe to the trap-information register |
| tinfo_level | output | 4 | Level to record |
| tinfo_vnum | output | 8 | Vector number to record |
| other_berr | input | 1 | Bus error seen on a non-vector access |
| berr_trap_req | output | 1 | Bus-error trap request to the interrupt controller |
| ret_pulse | input | 1 | Return-from-exception restores the stacked status |
| sr_vf | output | 1 | Vector-fail status bit |
| sfr_we | input | 1 | Substitute-address register write enable |
| sfr_wdata | input | 32 | Substitute-address register write data |
| sfr_rdata | output | 32 | Substitute-address register read-back |

## Verification
On every cycle, the assertions check the following:

- The request stays stable while it waits for a response.
- A substituted result always carries level 14 and no acknowledge.
- A trap request appears only after a non-vector bus error.
- The fail bit does not clear without a return.
- The read-back value always has bit 0 clear.

Only the bench scenarios can show which value ends up as the target. That covers the reset default, a rewritten register, and the old value winning on a same-cycle write. The scenarios also show that a pending exception is not consumed and that busy-time requests are ignored.

// File: rtl/vec_fault_sub.sv
module vec_fault_sub #(
  parameter int AW         = 32,
  parameter int IPLW       = 4,
  parameter int VNW        = 8,
  parameter int BERR_IPL   = 14,
  parameter logic [AW-1:0] RESET_ADDR = 32'h0000_0200,
  parameter logic [AW-1:0] VTAB_BASE  = 32'h0000_0004
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_take,
  input  logic [IPLW-1:0] exc_level,
  input  logic [VNW-1:0]  exc_vnum,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [AW-1:0]   mem_rdata,
  output logic            vec_valid,
  output logic [AW-1:0]   vec_target,
  output logic [IPLW-1:0] vec_ipl,
  output logic            vec_fail,
  output logic            exc_ack,
  output logic            tinfo_we,
  output logic [IPLW-1:0] tinfo_level,
  output logic [VNW-1:0]  tinfo_vnum,
  input  logic            other_berr,
  output logic            berr_trap_req,
  input  logic            ret_pulse,
  output logic            sr_vf,
  input  logic            sfr_we,
  input  logic [AW-1:0]   sfr_wdata,
  output logic [AW-1:0]   sfr_rdata
);
  localparam int SLOT = AW / 8;
  localparam logic [IPLW-1:0] TRAP_LVL = IPLW'(BERR_IPL);

  logic [AW-1:0]   vfa_q;
  logic [IPLW-1:0] lvl_q;
  logic [VNW-1:0]  vn_q;
  logic            resp, fault, start;

  assign resp      = mem_req && (mem_ack || mem_err);
  assign fault     = resp && mem_err;
  assign start     = exc_take && !mem_req;
  assign sfr_rdata = vfa_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vfa_q <= RESET_ADDR;
    else if (sfr_we) vfa_q <= {sfr_wdata[AW-1:1], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      lvl_q    <= '0;
      vn_q     <= '0;
    end else if (start) begin
      mem_req  <= 1'b1;
      mem_addr <= VTAB_BASE + AW'(exc_vnum) * AW'(SLOT);
      lvl_q    <= exc_level;
      vn_q     <= exc_vnum;
    end else if (resp) begin
      mem_req  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid   <= 1'b0;
      vec_target  <= '0;
      vec_ipl     <= '0;
      vec_fail    <= 1'b0;
      exc_ack     <= 1'b0;
      tinfo_we    <= 1'b0;
      tinfo_level <= '0;
      tinfo_vnum  <= '0;
    end else begin
      vec_valid <= resp;
      exc_ack   <= resp && !mem_err;
      tinfo_we  <= resp;
      if (resp) begin
        vec_target  <= mem_err ? vfa_q : mem_rdata;
        vec_ipl     <= mem_err ? TRAP_LVL : lvl_q;
        vec_fail    <= mem_err;
        tinfo_level <= lvl_q;
        tinfo_vnum  <= vn_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_vf         <= 1'b0;
      berr_trap_req <= 1'b0;
    end else begin
      berr_trap_req <= other_berr;
      if (fault) sr_vf <= 1'b1;
      else if (ret_pulse) sr_vf <= 1'b0;
    end
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !mem_err |=> mem_req && $stable(mem_addr));
  assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !mem_req);
  assert_fail_forces_lvl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_fail |-> vec_ipl == TRAP_LVL && !exc_ack && sr_vf);
  assert_no_vec_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    berr_trap_req |-> $past(other_berr));
  assert_vf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sr_vf && !ret_pulse |=> sr_vf);
  assert_vf_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_vf) |-> $past(ret_pulse));
  assert_out_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> $stable(vec_target) && $stable(vec_ipl) && $stable(vec_fail));
  assert_sfr_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rdata[0] == 1'b0);
endmodule

// File: tb/sim_vec_fault_sub.sv
module sim_vec_fault_sub;
  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_take = 0; logic [3:0] exc_level = 0; logic [7:0] exc_vnum = 0;
  logic mem_req; logic [31:0] mem_addr;
  logic mem_ack = 0, mem_err = 0; logic [31:0] mem_rdata = 0;
  logic vec_valid; logic [31:0] vec_target; logic [3:0] vec_ipl; logic vec_fail;
  logic exc_ack, tinfo_we; logic [3:0] tinfo_level; logic [7:0] tinfo_vnum;
  logic other_berr = 0, berr_trap_req, ret_pulse = 0, sr_vf;
  logic sfr_we = 0; logic [31:0] sfr_wdata = 0, sfr_rdata;

  int tests = 0, fails = 0;
  logic [31:0] vfa_m;
  logic vf_m;

  always #2 clk = ~clk;

  vec_fault_sub u0 (.*);

  function automatic logic [31:0] exp_addr(input logic [7:0] vn);
    return 32'h4 + {22'd0, vn, 2'b00};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fetch(input logic [3:0] lvl, input logic [7:0] vn, input logic err,
                       input logic [31:0] data, input int lat, input logic wr_same,
                       input logic [31:0] wval);
    logic [31:0] exp_t;
    exc_take = 1; exc_level = lvl; exc_vnum = vn;
    nclk(1);
    exc_take = 0;
    chk(mem_req === 1'b1, "R8 req", {31'd0, mem_req}, 1);
    chk(mem_addr === exp_addr(vn), "R8 addr", mem_addr, exp_addr(vn));
    exc_take = 1; exc_level = ~lvl; exc_vnum = ~vn;
    for (int i = 0; i < lat; i++) begin
      nclk(1);
      chk(mem_req === 1'b1 && mem_addr === exp_addr(vn), "R8 hold", mem_addr, exp_addr(vn));
    end
    exc_take = 0;
    mem_ack = !err; mem_err = err; mem_rdata = data;
    if (wr_same) begin sfr_we = 1; sfr_wdata = wval; end
    nclk(1);
    mem_ack = 0; mem_err = 0; sfr_we = 0;
    exp_t = err ? vfa_m : data;
    if (wr_same) vfa_m = {wval[31:1], 1'b0};
    if (err) vf_m = 1;
    chk(vec_valid === 1'b1 && mem_req === 1'b0, "R8 valid", {31'd0, vec_valid}, 1);
    chk(vec_target === exp_t, err ? "R2 target" : "R1 target", vec_target, exp_t);
    chk(vec_ipl === (err ? 4'd14 : lvl), err ? "R2 ipl" : "R1 ipl (R9)", {28'd0, vec_ipl}, {28'd0, err ? 4'd14 : lvl});
    chk(vec_fail === err && exc_ack === !err, "R1/R2 ack", {30'd0, vec_fail, exc_ack}, {30'd0, err, !err});
    chk(sr_vf === vf_m, "R2 vf", {31'd0, sr_vf}, {31'd0, vf_m});
    chk(tinfo_we === 1'b1 && tinfo_level === lvl && tinfo_vnum === vn, "R6 tinfo R9",
        {20'd0, tinfo_level, tinfo_vnum}, {20'd0, lvl, vn});
    chk(berr_trap_req === 1'b0, "R3 no trap", {31'd0, berr_trap_req}, 0);
    nclk(1);
    chk(vec_valid === 0 && exc_ack === 0 && tinfo_we === 0 && vec_target === exp_t,
        "R10 hold", vec_target, exp_t);
    chk(sfr_rdata === vfa_m, "R5 readback", sfr_rdata, vfa_m);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd17));
    nclk(3); rst_n = 1; nclk(1);
    vfa_m = 32'h200; vf_m = 0;
    chk(mem_req === 0 && vec_valid === 0 && exc_ack === 0 && tinfo_we === 0 &&
        berr_trap_req === 0 && sr_vf === 0, "R11 reset", {31'd0, sr_vf}, 0);
    chk(sfr_rdata === 32'h200, "R4 reset value", sfr_rdata, 32'h200);

    fetch(4'd5, 8'd3, 0, 32'h0000_1234, 1, 0, 0);
    fetch(4'd6, 8'd9, 1, 32'hDEAD_BEEF, 0, 0, 0);
    nclk(3);
    chk(sr_vf === 1, "R10 sticky", {31'd0, sr_vf}, 1);
    ret_pulse = 1; nclk(1); ret_pulse = 0; vf_m = 0;
    chk(sr_vf === 0, "R7 return clears", {31'd0, sr_vf}, 0);

    sfr_we = 1; sfr_wdata = 32'h0000_0A01; nclk(1); sfr_we = 0; vfa_m = 32'h0000_0A00;
    chk(sfr_rdata === 32'h0A00, "R4 bit0 forced", sfr_rdata, 32'h0A00);
    fetch(4'd2, 8'd255, 1, 32'h5555_5555, 2, 0, 0);
    fetch(4'd3, 8'd0, 1, 32'h1, 0, 1, 32'h0000_0C07);

    ret_pulse = 1; mem_err = 0;
    exc_take = 1; exc_level = 1; exc_vnum = 1; nclk(1); exc_take = 0; ret_pulse = 0;
    vf_m = 0;
    ret_pulse = 1; mem_err = 1; nclk(1); ret_pulse = 0; mem_err = 0; vf_m = 1;
    chk(sr_vf === 1, "R7 error wins over return", {31'd0, sr_vf}, 1);
    nclk(1);

    other_berr = 1; nclk(1); other_berr = 0;
    chk(berr_trap_req === 1, "R3 other berr trap", {31'd0, berr_trap_req}, 1);
    nclk(1);
    chk(berr_trap_req === 0, "R3 trap pulse", {31'd0, berr_trap_req}, 0);

    for (int k = 0; k < 60; k++) begin
      logic [31:0] w = $urandom;
      logic e = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) begin
        sfr_we = 1; sfr_wdata = w; nclk(1); sfr_we = 0; vfa_m = {w[31:1], 1'b0};
      end
      if ($urandom_range(0, 4) == 0) begin
        ret_pulse = 1; nclk(1); ret_pulse = 0; vf_m = 0;
      end
      fetch(4'($urandom), 8'($urandom), e, $urandom, $urandom_range(0, 3),
            $urandom_range(0, 5) == 0, $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule